// File: doc/BRIEF.md
# Address-latched fast read sequencer

This block runs a single read cycle on an external parallel bus for devices that latch their address on a one-cycle address-valid strobe. A requester presents an address and an already decoded chip-select index. When the sequencer is idle it accepts the request. It then pulls the selected active-low chip select, pulses the address-valid strobe and drives the address. After a programmable delay it asserts the active-low output enable for two cycles and captures the 16-bit data bus. It returns the word with a one-cycle done strobe.

Each chip select has its own timing record. The record holds an address-hold flag, a 2-bit strobe-to-enable delay and a 4-bit first-segment length. It is written through a simple write port. The record for the addressed chip select is captured when a request is accepted, so later writes do not disturb a read in flight. All bus outputs come from registers.

Top module: `xrd_fast_read`

## Requirements
- R1: After reset, every chip select, the address-valid strobe and the output enable are high, the address bus is zero, rd_done is low and req_ready is high. Every timing record resets to zero.
- R2: A request is accepted at a rising edge where req_valid and req_ready are both high. The cycle after that edge is cycle 0. In cycle 0, only the chip select with index req_cs goes low, bus_adv_n is low and bus_addr carries req_addr. bus_adv_n is high in every other cycle.
- R3: If the address-hold flag of the selected record is 1, bus_addr keeps the address in cycle 1. If the flag is 0, bus_addr is zero in cycle 1. bus_addr is zero in every cycle other than the address cycles.
- R4: Output enable first goes low in cycle T. T is the largest of three values: the strobe-to-enable delay, the first-segment length, and the smallest legal value. The smallest legal value is 2 when address hold is set and 1 when it is clear.
- R5: bus_oe_n is low in exactly two cycles, T and T+1. It is never low while bus_adv_n is low or while bus_addr is non-zero.
- R6: bus_data_in is captured at the edge that ends cycle T+1. In cycle T+2 the chip select and output enable are high, rd_done is high for that one cycle and rd_data holds the captured word.
- R7: req_ready is low from cycle 0 through cycle T+1. A request presented while req_ready is low is ignored, and no new chip-select activity follows it.
- R8: A write port stores a record for the chip select given by cfg_sel when cfg_we is high. Each chip select keeps its own record. Writes to an index of NCS or above change nothing.
- R9: A read uses the record that was stored at the edge where the read was accepted. Writing that record during the read does not change the read's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing record write enable |
| cfg_sel | input | CSW | Chip-select index of the record being written |
| cfg_addr_hold | input | 1 | Address-hold flag to write |
| cfg_adv_oe | input | 2 | Strobe-to-enable delay to write |
| cfg_rd_hold | input | 4 | First-segment length to write |
| req_valid | input | 1 | Read request |
| req_cs | input | CSW | Decoded chip-select index of the request |
| req_addr | input | AW | Read address |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_adv_n | output | 1 | Active-low address-valid strobe |
| bus_addr | output | AW | External address bus |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_data_in | input | DW | External data bus |
| rd_done | output | 1 | One-cycle read completion strobe |
| rd_data | output | DW | Captured read word |

## Verification
The checker assumes that req_cs is always below NCS. With that assumption, every accepted read pulls exactly one chip select low. The checker also assumes that the requester never relies on a read address of zero to tell the address phase apart from an idle bus.

The stimulus draws chip-select indices only from the range 0 to NCS-1 and always draws non-zero addresses. Timing records are written freely, including while a read is in flight and with out-of-range indices. Busy-time requests are injected on purpose, so that the ignore rule is exercised at the bus pins.

// File: rtl/xrd_pkg.sv
package xrd_pkg;
  localparam int ADV_OE_W  = 2;
  localparam int RD_HOLD_W = 4;
  localparam int CNT_W     = RD_HOLD_W + 1;

  typedef struct packed {
    logic                 addr_hold;
    logic [ADV_OE_W-1:0]  adv_oe;
    logic [RD_HOLD_W-1:0] rd_hold;
  } xrd_cfg_t;
endpackage

// File: rtl/xrd_cfg_bank.sv
module xrd_cfg_bank
  import xrd_pkg::*;
#(
  parameter int NCS = 6,
  parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CSW-1:0] wr_sel,
  input  xrd_cfg_t       wr_val,
  input  logic [CSW-1:0] rd_sel,
  output xrd_cfg_t       rd_val
);
  xrd_cfg_t recs [NCS];

  for (genvar i = 0; i < NCS; i++) begin : g_rec
    always_ff @(posedge clk) begin
      if (rst)
        recs[i] <= '0;
      else if (wr_en && (wr_sel == CSW'(i)))
        recs[i] <= wr_val;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCS; i++)
      if (rd_sel == CSW'(i)) rd_val = recs[i];
  end
endmodule

// File: rtl/xrd_seg_calc.sv
module xrd_seg_calc
  import xrd_pkg::*;
(
  input  xrd_cfg_t         cfg,
  output logic [CNT_W-1:0] oe_first
);
  logic [CNT_W-1:0] floor_v, ao_v, rh_v, m1;

  always_comb begin
    floor_v  = cfg.addr_hold ? CNT_W'(2) : CNT_W'(1);
    ao_v     = CNT_W'(cfg.adv_oe);
    rh_v     = CNT_W'(cfg.rd_hold);
    m1       = (ao_v > rh_v) ? ao_v : rh_v;
    oe_first = (m1 > floor_v) ? m1 : floor_v;
  end
endmodule

// File: rtl/xrd_seq_core.sv
module xrd_seq_core
  import xrd_pkg::*;
#(
  parameter int AW  = 9,
  parameter int DW  = 16,
  parameter int NCS = 6,
  parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CSW-1:0]   req_cs,
  input  logic [AW-1:0]    req_addr,
  input  logic             hold_in,
  input  logic [CNT_W-1:0] oe_first,
  output logic             req_ready,
  output logic [NCS-1:0]   bus_cs_n,
  output logic             bus_adv_n,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_oe_n,
  input  logic [DW-1:0]    bus_data_in,
  output logic             rd_done,
  output logic [DW-1:0]    rd_data
);
  typedef enum logic {S_IDLE, S_BUSY} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, nxt, oe_at, oe_last;
  logic             hold_q;
  logic [AW-1:0]    addr_lat;
  logic [NCS-1:0]   cs_dec;

  for (genvar i = 0; i < NCS; i++) begin : g_dec
    assign cs_dec[i] = (req_cs == CSW'(i));
  end

  assign nxt       = cnt + CNT_W'(1);
  assign oe_last   = oe_at + CNT_W'(1);
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      oe_at     <= '0;
      hold_q    <= 1'b0;
      addr_lat  <= '0;
      bus_cs_n  <= '1;
      bus_adv_n <= 1'b1;
      bus_addr  <= '0;
      bus_oe_n  <= 1'b1;
      rd_done   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            st        <= S_BUSY;
            cnt       <= '0;
            oe_at     <= oe_first;
            hold_q    <= hold_in;
            addr_lat  <= req_addr;
            bus_cs_n  <= ~cs_dec;
            bus_adv_n <= 1'b0;
            bus_addr  <= req_addr;
            bus_oe_n  <= 1'b1;
          end
        end
        default: begin
          bus_adv_n <= 1'b1;
          cnt       <= nxt;
          bus_addr  <= (cnt == '0 && hold_q) ? addr_lat : '0;
          bus_oe_n  <= !((nxt == oe_at) || (nxt == oe_last));
          if (cnt == oe_last) begin
            rd_data  <= bus_data_in;
            bus_cs_n <= '1;
            bus_oe_n <= 1'b1;
            bus_addr <= '0;
            rd_done  <= 1'b1;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xrd_fast_read.sv
module xrd_fast_read
  import xrd_pkg::*;
#(
  parameter int AW  = 9,
  parameter int DW  = 16,
  parameter int NCS = 6,
  parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CSW-1:0]       cfg_sel,
  input  logic                 cfg_addr_hold,
  input  logic [ADV_OE_W-1:0]  cfg_adv_oe,
  input  logic [RD_HOLD_W-1:0] cfg_rd_hold,
  input  logic                 req_valid,
  input  logic [CSW-1:0]       req_cs,
  input  logic [AW-1:0]        req_addr,
  output logic                 req_ready,
  output logic [NCS-1:0]       bus_cs_n,
  output logic                 bus_adv_n,
  output logic [AW-1:0]        bus_addr,
  output logic                 bus_oe_n,
  input  logic [DW-1:0]        bus_data_in,
  output logic                 rd_done,
  output logic [DW-1:0]        rd_data
);
  xrd_cfg_t         wr_rec, sel_rec;
  logic [CNT_W-1:0] oe_first;

  assign wr_rec = '{addr_hold: cfg_addr_hold, adv_oe: cfg_adv_oe, rd_hold: cfg_rd_hold};

  xrd_cfg_bank #(.NCS(NCS), .CSW(CSW)) i_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_val(wr_rec),
    .rd_sel(req_cs), .rd_val(sel_rec)
  );

  xrd_seg_calc i_calc (.cfg(sel_rec), .oe_first(oe_first));

  xrd_seq_core #(.AW(AW), .DW(DW), .NCS(NCS), .CSW(CSW)) i_core (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cs(req_cs), .req_addr(req_addr),
    .hold_in(sel_rec.addr_hold), .oe_first(oe_first), .req_ready(req_ready),
    .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_addr(bus_addr), .bus_oe_n(bus_oe_n),
    .bus_data_in(bus_data_in), .rd_done(rd_done), .rd_data(rd_data)
  );
endmodule

// File: rtl/xrd_fast_read_chk.sv
module xrd_fast_read_chk
  import xrd_pkg::*;
#(
  parameter int AW  = 9,
  parameter int DW  = 16,
  parameter int NCS = 6,
  parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [CSW-1:0]       cfg_sel,
  input logic                 cfg_addr_hold,
  input logic [ADV_OE_W-1:0]  cfg_adv_oe,
  input logic [RD_HOLD_W-1:0] cfg_rd_hold,
  input logic                 req_valid,
  input logic [CSW-1:0]       req_cs,
  input logic [AW-1:0]        req_addr,
  input logic                 req_ready,
  input logic [NCS-1:0]       bus_cs_n,
  input logic                 bus_adv_n,
  input logic [AW-1:0]        bus_addr,
  input logic                 bus_oe_n,
  input logic [DW-1:0]        bus_data_in,
  input logic                 rd_done,
  input logic [DW-1:0]        rd_data
);
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));

  p_adv_single_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_adv_n |=> bus_adv_n);

  p_adv_opens_cs_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_adv_n |-> (bus_cs_n != '1) && ($past(bus_cs_n) == '1));

  p_oe_clear_of_addr_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> bus_adv_n && (bus_addr == '0) && (bus_cs_n != '1));

  p_oe_pair_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_oe_n) |=> !bus_oe_n);

  p_oe_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n && !$past(bus_oe_n)) |=> bus_oe_n);

  p_done_closes_r6: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (bus_cs_n == '1) && bus_oe_n && req_ready && $past(!bus_oe_n));

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n != '1) |-> !req_ready);
endmodule

bind xrd_fast_read xrd_fast_read_chk #(.AW(AW), .DW(DW), .NCS(NCS), .CSW(CSW)) i_chk (.*);

// File: tb/test_xrd_fast_read.sv
module test_xrd_fast_read;
  localparam int AW = 9, DW = 16, NCS = 6, CSW = 3;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_addr_hold = 0;
  logic [CSW-1:0] cfg_sel = 0, req_cs = 0;
  logic [1:0] cfg_adv_oe = 0;
  logic [3:0] cfg_rd_hold = 0;
  logic req_valid = 0, req_ready, bus_adv_n, bus_oe_n, rd_done;
  logic [AW-1:0] req_addr = 0, bus_addr;
  logic [NCS-1:0] bus_cs_n;
  logic [DW-1:0] bus_data_in = 0, rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit m_h [NCS];
  int m_ao [NCS], m_rh [NCS];

  always #5 clk = ~clk;

  xrd_fast_read #(.AW(AW), .DW(DW), .NCS(NCS), .CSW(CSW)) i_xrd_fast_read (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int oe_first(input bit h, input int ao, input int rh);
    int t = h ? 2 : 1;
    if (ao > t) t = ao;
    if (rh > t) t = rh;
    return t;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic write_cfg(input int sel, input bit h, input int ao, input int rh);
    cfg_we = 1; cfg_sel = CSW'(sel); cfg_addr_hold = h;
    cfg_adv_oe = 2'(ao); cfg_rd_hold = 4'(rh);
    @(negedge clk);
    cfg_we = 0;
    if (sel < NCS) begin m_h[sel] = h; m_ao[sel] = ao; m_rh[sel] = rh; end
  endtask

  // poke: 1 = busy-time request, 2 = rewrite own record mid-read
  task automatic do_read(input int cs, input logic [AW-1:0] a, input logic [DW-1:0] w, input int poke);
    int t; bit h; bit oe_prev = 0; bit bad;
    logic [NCS-1:0] exp_cs;
    h = m_h[cs];
    t = oe_first(m_h[cs], m_ao[cs], m_rh[cs]);
    exp_cs = ~(NCS'(1) << cs);
    req_valid = 1; req_cs = CSW'(cs); req_addr = a;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k <= t + 1; k++) begin
      bad = (bus_cs_n != exp_cs);
      chk(!bad, "R2 cs", bus_cs_n, exp_cs);
      chk(bus_adv_n == (k != 0), "R2 adv", bus_adv_n, k != 0);
      if (k == 0) chk(bus_addr == a, "R2 addr", bus_addr, a);
      else if (k == 1 && h) chk(bus_addr == a, "R3 held addr", bus_addr, a);
      else chk(bus_addr == 0, "R3 addr idle", bus_addr, 0);
      chk(bus_oe_n == !(k == t || k == t + 1), "R4 R5 oe", bus_oe_n, !(k == t || k == t + 1));
      chk(!req_ready && !rd_done, "R7 busy", {req_ready, rd_done}, 0);
      bus_data_in = (!bus_oe_n && oe_prev) ? w : ~w;
      oe_prev = !bus_oe_n;
      if (k == 1 && poke == 1) begin req_valid = 1; req_cs = CSW'((cs + 1) % NCS); req_addr = ~a; end
      if (k == 2 && poke == 1) req_valid = 0;
      if (k == 1 && poke == 2) begin
        cfg_we = 1; cfg_sel = CSW'(cs); cfg_addr_hold = !h; cfg_adv_oe = 2'd3; cfg_rd_hold = 4'd12;
      end
      if (k == 2 && poke == 2) begin
        cfg_we = 0; m_h[cs] = !h; m_ao[cs] = 3; m_rh[cs] = 12;
      end
      @(negedge clk);
    end
    chk(rd_done == 1, "R6 done", rd_done, 1);
    chk(rd_data == w, "R6 data", rd_data, w);
    chk(bus_cs_n == '1 && bus_oe_n && bus_adv_n, "R6 closed", {bus_cs_n, bus_oe_n, bus_adv_n}, '1);
    chk(req_ready == 1, "R7 ready", req_ready, 1);
    bus_data_in = 0;
    @(negedge clk);
    chk(rd_done == 0, "R6 done pulse", rd_done, 0);
    chk(bus_cs_n == '1, "R7 ignored request", bus_cs_n, '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int i = 0; i < NCS; i++) begin m_h[i] = 0; m_ao[i] = 0; m_rh[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(bus_cs_n == '1 && bus_adv_n && bus_oe_n, "R1 strobes", {bus_cs_n, bus_adv_n, bus_oe_n}, '1);
    chk(bus_addr == 0 && !rd_done && req_ready, "R1 addr done ready", {bus_addr, rd_done, req_ready}, 1);
    // R1 R8 reset records give T = 1
    do_read(0, 9'h055, 16'hA5C3, 0);
    // R3 R4 hold only: T = 2
    write_cfg(1, 1, 0, 0);
    do_read(1, 9'h1F0, 16'h1234, 0);
    // R4 delay wins: T = 3
    write_cfg(2, 0, 3, 0);
    do_read(2, 9'h101, 16'hBEEF, 0);
    // R4 segment length wins: T = 15
    write_cfg(3, 1, 3, 15);
    do_read(3, 9'h0AA, 16'h0F0F, 0);
    // R4 R3 hold with delay 3, length 2: T = 3
    write_cfg(4, 1, 3, 2);
    do_read(4, 9'h003, 16'hFFFF, 0);
    // R8 out-of-range write changes nothing; record 5 still zero
    write_cfg(7, 1, 3, 15);
    do_read(5, 9'h1FF, 16'h8001, 0);
    // R8 records stay separate: cs 2 still T = 3
    do_read(2, 9'h0C3, 16'h7E7E, 0);
    // R7 busy-time request ignored
    do_read(3, 9'h111, 16'h4321, 1);
    // R9 mid-read rewrite has no effect on this read, then applies
    do_read(0, 9'h042, 16'h5A5A, 2);
    do_read(0, 9'h043, 16'hC0DE, 0);
    for (int n = 0; n < 80; n++) begin
      int cs = $urandom_range(0, NCS - 1);
      logic [AW-1:0] a = AW'($urandom_range(1, (1 << AW) - 1));
      if ($urandom_range(0, 2) == 0)
        write_cfg(cs, 1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 15));
      do_read(cs, a, DW'($urandom), $urandom_range(0, 3) == 0 ? 1 : 0);
    end
    finish_run();
  end
endmodule